// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block sits between two 18-bit buses, called A and B, and passes data across in both directions. Each direction has its own storage cell and its own three control inputs: a latch enable, a capture clock and an output enable. When the latch enable is high, data flows straight through. When it is low, the cell holds its contents, and it loads new data only on a rising edge of its capture clock. The A-to-B direction drives the B port and the B-to-A direction drives the A port. Each port is modelled with separate data-in, data-out and drive-enable signals.

Both ports hold the last value that was driven onto them. When an external driver lets go of a port, the direction that reads that port goes on seeing the last driven word and never reads a floating value. The capture clocks are sampled with the system clock and their rising edges are found from those samples, so a clocked load reaches the output one system-clock cycle after the edge is seen. The transparent path has no register in it. The outputs of both directions fan out to all eighteen channels, and all channels share the same control signals.

Top module: `bus_xcvr`

## Requirements
- R1: While synchronous reset (rst_n low) is applied, both storage cells and both bus-hold registers clear to zero. A port that is not driven after reset therefore reads as zero through a transparent path.
- R2: When le_ab is 1, b_out equals the effective A input in the same cycle, with no clock involved. The effective A input is a_in when a_in_drv is 1, and otherwise the held A value.
- R3: When le_ab is 0 and clk_ab does not rise, b_out keeps its value while A changes.
- R4: When le_ab is 0, a rising edge on clk_ab seen at a system-clock edge loads the effective A input, and b_out shows it after that edge. A falling edge on clk_ab loads nothing.
- R5: When le_ab falls from 1 to 0, b_out keeps the effective A value that was present at the last system-clock edge while le_ab was 1. A value applied together with the falling enable is not taken.
- R6: The B-to-A path behaves the same way as the A-to-B path, using le_ba, clk_ba and the effective B input to drive a_out. This covers transparent, held and clocked modes.
- R7: b_out_en is 1 exactly when oe_ab is 1 (active high) and reset is released. a_out_en is 1 exactly when oe_ba_n is 0 (active low) and reset is released.
- R8: When a_in_drv goes from 1 to 0, the effective A input stays at the last a_in value that was sampled while a_in_drv was 1. Later values on a_in have no effect.
- R9: When b_in_drv goes from 1 to 0, the effective B input stays at the last b_in value that was sampled while b_in_drv was 1. This holds even while both outputs are disabled.
- R10: A reset applied after a port has been driven clears that port's held value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Value on the A bus from an external driver |
| a_in_drv | input | 1 | External driver active on the A bus |
| a_out | output | 18 | B-to-A path data for the A bus |
| a_out_en | output | 1 | A port driven by this block |
| b_in | input | 18 | Value on the B bus from an external driver |
| b_in_drv | input | 1 | External driver active on the B bus |
| b_out | output | 18 | A-to-B path data for the B bus |
| b_out_en | output | 1 | B port driven by this block |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| clk_ab | input | 1 | A-to-B capture clock |
| oe_ab | input | 1 | B port output enable, active high |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| clk_ba | input | 1 | B-to-A capture clock |
| oe_ba_n | input | 1 | A port output enable, active low |

## Verification
The bench drops the latch enable in the same cycle that new data arrives. A cell that took its value from the current input instead of the last sampled one would show the new word there. It holds the capture clock high, and later drives it low, while the data changes. A design that loads on levels or on falling edges would then pass the changed data. It lets go of each port while both outputs are off and then opens the transparent path, so a bus-hold that follows the undriven pin, or is not cleared by a later reset, shows the wrong word. Both enable polarities are driven to each level, so an enable with its sense swapped is exposed.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the bidirectional registered transceiver.
package xcvr_pkg;

    // Default data width of each direction.
    localparam int XCVR_DATA_W = 18;

    // Update mode of one storage cell in a given system-clock cycle.
    typedef enum logic [1:0] {
        CELL_HOLD    = 2'd0,
        CELL_PASS    = 2'd1,
        CELL_CLOCKED = 2'd2
    } cell_mode_e;

    // Select the cell mode. The latch enable wins over the clock edge.
    function automatic cell_mode_e pick_mode(input logic le, input logic rise);
        if (le)        return CELL_PASS;
        else if (rise) return CELL_CLOCKED;
        else           return CELL_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_bus_hold.sv
// Bus-hold model for one port.
// While the external driver is active, the pin value passes through and is
// also registered. When the driver lets go, the last registered value is used.
// Assumes a synchronous active-low reset that clears the held word.
module xcvr_bus_hold #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic         drv,
    output logic [W-1:0] val
);

    logic [W-1:0] held_q;

    // Track the last value driven onto the port.
    always_ff @(posedge clk) begin
        if (!rst_n)   held_q <= '0;
        else if (drv) held_q <= pin;
    end

    // The effective value is the live pin while driven, otherwise the held word.
    always_comb val = drv ? pin : held_q;

endmodule

// File: rtl/xcvr_edge_detect.sv
// Rising-edge detector for a capture clock that is sampled as data.
// The previous sample is taken even while reset is applied. A clock that is
// already high when reset is released therefore gives no false edge.
module xcvr_edge_detect (
    input  logic clk,
    input  logic level,
    output logic rise
);

    logic prev_q;

    // Remember the capture-clock level from the last system-clock edge.
    always_ff @(posedge clk) prev_q <= level;

    // A rise is a high level now after a low level one cycle earlier.
    always_comb rise = level & ~prev_q;

endmodule

// File: rtl/xcvr_store_cell.sv
// Storage cell for one direction, working as a latch and a flip-flop together.
// Transparent mode: the output follows din with no register in the path, and
// the register keeps the latest sampled value.
// Held mode: the output is the register.
// Clocked mode: a sampled rising edge on cap_clk loads din.
// Assumes cap_clk changes slowly compared with clk.
module xcvr_store_cell
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         cap_clk,
    output logic [W-1:0] dout
);

    logic         cap_rise;
    cell_mode_e   mode;
    logic [W-1:0] store_q;

    xcvr_edge_detect u_edge (
        .clk   (clk),
        .level (cap_clk),
        .rise  (cap_rise)
    );

    // Decide how the cell updates this cycle.
    always_comb mode = pick_mode(le, cap_rise);

    // Load the register in transparent or clocked mode, and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 store_q <= '0;
        else if (mode != CELL_HOLD) store_q <= din;
    end

    // Pass din straight through while transparent, else show the stored word.
    always_comb dout = le ? din : store_q;

endmodule

// File: rtl/xcvr_path.sv
// One transfer direction: bus-hold on the source port, a storage cell, and
// output-enable gating for the destination port.
// OE_LOW selects an active-low output enable. The enable is forced off while
// reset is applied.
module xcvr_path #(
    parameter int W      = 18,
    parameter bit OE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_pin,
    input  logic         src_drv,
    input  logic         le,
    input  logic         cap_clk,
    input  logic         oe,
    output logic [W-1:0] dst_out,
    output logic         dst_en
);

    logic [W-1:0] src_val;
    logic         oe_act;

    xcvr_bus_hold #(.W(W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (src_pin),
        .drv   (src_drv),
        .val   (src_val)
    );

    xcvr_store_cell #(.W(W)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (src_val),
        .le      (le),
        .cap_clk (cap_clk),
        .dout    (dst_out)
    );

    // Pick the output-enable polarity from the parameter.
    generate
        if (OE_LOW) begin : g_oe_low
            always_comb oe_act = ~oe;
        end else begin : g_oe_high
            always_comb oe_act = oe;
        end
    endgenerate

    // Drive the destination port only when enabled and out of reset.
    always_comb dst_en = oe_act & rst_n;

endmodule

// File: rtl/bus_xcvr.sv
// Top level: two independent transfer paths between the A and B ports.
// A-to-B uses an active-high output enable. B-to-A uses an active-low one.
// Each bus-hold follows only the external driver of its port, so the two
// transparent paths never form a combinational loop.
module bus_xcvr #(
    parameter int DATA_W = xcvr_pkg::XCVR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    input  logic              a_in_drv,
    output logic [DATA_W-1:0] a_out,
    output logic              a_out_en,
    input  logic [DATA_W-1:0] b_in,
    input  logic              b_in_drv,
    output logic [DATA_W-1:0] b_out,
    output logic              b_out_en,
    input  logic              le_ab,
    input  logic              clk_ab,
    input  logic              oe_ab,
    input  logic              le_ba,
    input  logic              clk_ba,
    input  logic              oe_ba_n
);

    xcvr_path #(.W(DATA_W), .OE_LOW(1'b0)) u_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_pin (a_in),
        .src_drv (a_in_drv),
        .le      (le_ab),
        .cap_clk (clk_ab),
        .oe      (oe_ab),
        .dst_out (b_out),
        .dst_en  (b_out_en)
    );

    xcvr_path #(.W(DATA_W), .OE_LOW(1'b1)) u_ba (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_pin (b_in),
        .src_drv (b_in_drv),
        .le      (le_ba),
        .cap_clk (clk_ba),
        .oe      (oe_ba_n),
        .dst_out (a_out),
        .dst_en  (a_out_en)
    );

endmodule

// File: rtl/bus_xcvr_checker.sv
// Port-level properties of bus_xcvr, attached to it with bind.
module bus_xcvr_checker #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_in,
    input logic              a_in_drv,
    input logic [DATA_W-1:0] a_out,
    input logic              a_out_en,
    input logic [DATA_W-1:0] b_in,
    input logic              b_in_drv,
    input logic [DATA_W-1:0] b_out,
    input logic              b_out_en,
    input logic              le_ab,
    input logic              clk_ab,
    input logic              oe_ab,
    input logic              le_ba,
    input logic              clk_ba,
    input logic              oe_ba_n
);

    // R7: both ports are undriven while reset is applied.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r7_off_in_reset: assert (!a_out_en && !b_out_en);
        end
    end

    // R7: the two enables have opposite polarity.
    a_r7_b_enable: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ab |-> b_out_en);
    a_r7_a_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ba_n |-> a_out_en);

    // R2: the transparent path passes the driven A word in the same cycle.
    a_r2_pass_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ab && a_in_drv) |-> (b_out == a_in));

    // R3: with no rising edge and no transparency, B output is frozen.
    a_r3_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && $past(!le_ab) && $past(rst_n)
         && !($past(clk_ab) && !$past(clk_ab, 2))) |-> $stable(b_out));

    // R4: a sampled rising edge of clk_ab loads the driven A word.
    a_r4_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && $past(!le_ab) && $past(rst_n) && $past(a_in_drv)
         && $past(clk_ab) && !$past(clk_ab, 2)) |-> (b_out == $past(a_in)));

    // R6: the B-to-A path freezes in the same way.
    a_r6_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ba && $past(!le_ba) && $past(rst_n)
         && !($past(clk_ba) && !$past(clk_ba, 2))) |-> $stable(a_out));

    // R8: after the A driver lets go, the last driven word is what passes.
    a_r8_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_in_drv && $past(a_in_drv) && $past(rst_n) && le_ab)
        |-> (b_out == $past(a_in)));

endmodule

bind bus_xcvr bus_xcvr_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bus_xcvr_test.sv
`timescale 1ns/1ps
// Directed bench for bus_xcvr: one task per scenario.
module bus_xcvr_test;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         a_in_drv, b_in_drv;
    logic [W-1:0] a_out, b_out;
    logic         a_out_en, b_out_en;
    logic         le_ab, clk_ab, oe_ab, le_ba, clk_ba, oe_ba_n;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    bus_xcvr #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_in_drv(a_in_drv), .a_out(a_out), .a_out_en(a_out_en),
        .b_in(b_in), .b_in_drv(b_in_drv), .b_out(b_out), .b_out_en(b_out_en),
        .le_ab(le_ab), .clk_ab(clk_ab), .oe_ab(oe_ab),
        .le_ba(le_ba), .clk_ba(clk_ba), .oe_ba_n(oe_ba_n)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Move one cycle on; inputs and checks happen 1 ns after the rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    // R1, R7: reset state, enables off in reset, cleared storage.
    task automatic t_reset();
        a_in = 18'h3FFFF; b_in = 18'h2AAAA; a_in_drv = 0; b_in_drv = 0;
        le_ab = 0; clk_ab = 0; le_ba = 0; clk_ba = 0;
        oe_ab = 1; oe_ba_n = 0;
        rst_n = 1'b0;
        repeat (3) tick();
        check("R7 b_out_en in reset", W'(b_out_en), W'(0));
        check("R7 a_out_en in reset", W'(a_out_en), W'(0));
        rst_n = 1'b1;
        settle();
        check("R7 b_out_en high enable", W'(b_out_en), W'(1));
        check("R7 a_out_en low enable", W'(a_out_en), W'(1));
        check("R1 b_out cleared", b_out, '0);
        check("R1 a_out cleared", a_out, '0);
        le_ab = 1; le_ba = 1;
        settle();
        check("R1 A hold cleared", b_out, '0);
        check("R1 B hold cleared", a_out, '0);
        oe_ab = 0; oe_ba_n = 1;
        settle();
        check("R7 b_out_en off", W'(b_out_en), W'(0));
        check("R7 a_out_en off", W'(a_out_en), W'(0));
        le_ab = 0; le_ba = 0;
        tick();
    endtask

    // R2, R5: transparent flow, then switching to latched while data changes.
    task automatic t_ab_transparent();
        a_in_drv = 1; a_in = 18'h01234; le_ab = 1;
        settle();
        check("R2 pass first", b_out, 18'h01234);
        a_in = 18'h2BEEF;
        settle();
        check("R2 pass second", b_out, 18'h2BEEF);
        tick();
        a_in = 18'h15555; le_ab = 0;
        settle();
        check("R5 keeps last sampled", b_out, 18'h2BEEF);
        tick();
        check("R5 still held", b_out, 18'h2BEEF);
    endtask

    // R3, R4: held and clocked modes on A-to-B.
    task automatic t_ab_clocked();
        le_ab = 0; clk_ab = 0; a_in = 18'h00ABC;
        tick();
        a_in = 18'h3C3C3;
        tick();
        check("R3 hold while A changes", b_out, 18'h2BEEF);
        clk_ab = 1;
        tick();
        check("R4 rise loads A", b_out, 18'h3C3C3);
        a_in = 18'h11111;
        repeat (2) tick();
        check("R3 clock high steady", b_out, 18'h3C3C3);
        clk_ab = 0;
        repeat (2) tick();
        check("R4 falling edge ignored", b_out, 18'h3C3C3);
        clk_ab = 1;
        tick();
        check("R4 second rise loads", b_out, 18'h11111);
        clk_ab = 0;
        tick();
    endtask

    // R6: every mode on B-to-A.
    task automatic t_ba_modes();
        b_in_drv = 1; b_in = 18'h0F0F0; le_ba = 1; clk_ba = 0;
        settle();
        check("R6 BA transparent", a_out, 18'h0F0F0);
        tick();
        b_in = 18'h32100; le_ba = 0;
        settle();
        check("R6 BA latch on fall", a_out, 18'h0F0F0);
        tick();
        b_in = 18'h07777;
        tick();
        check("R6 BA held", a_out, 18'h0F0F0);
        clk_ba = 1;
        tick();
        check("R6 BA clocked load", a_out, 18'h07777);
        b_in = 18'h00001;
        clk_ba = 0;
        repeat (2) tick();
        check("R6 BA falling ignored", a_out, 18'h07777);
    endtask

    // R8, R9: bus-hold with both outputs tri-stated.
    task automatic t_bus_hold();
        oe_ab = 0; oe_ba_n = 1; le_ab = 0; le_ba = 0;
        a_in_drv = 1; a_in = 18'h24680;
        b_in_drv = 1; b_in = 18'h13579;
        tick();
        a_in_drv = 0; b_in_drv = 0;
        a_in = 18'h3FFFF; b_in = 18'h00000;
        repeat (2) tick();
        check("R7 both off during hold", W'({a_out_en, b_out_en}), W'(0));
        le_ab = 1; le_ba = 1;
        settle();
        check("R8 A holds last driven", b_out, 18'h24680);
        check("R9 B holds last driven", a_out, 18'h13579);
        clk_ab = 1;
        tick();
        le_ab = 0;
        clk_ab = 0;
        tick();
        check("R8 held value stored", b_out, 18'h24680);
        le_ba = 0;
    endtask

    // R10: reset clears held values after the ports have been driven.
    task automatic t_reset_clears_hold();
        a_in_drv = 1; a_in = 18'h2DEAD; b_in_drv = 1; b_in = 18'h1CAFE;
        tick();
        a_in_drv = 0; b_in_drv = 0;
        do_reset();
        le_ab = 1; le_ba = 1;
        settle();
        check("R10 A hold cleared", b_out, '0);
        check("R10 B hold cleared", a_out, '0);
        le_ab = 0; le_ba = 0;
        tick();
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_ab_transparent();
        t_ab_clocked();
        t_ba_modes();
        t_bus_hold();
        t_reset_clears_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule